// File: doc/BRIEF.md
# Embedded video sync decoder

This block watches an interleaved YCbCr byte stream for the timing reference codes embedded in the video. The stream is either 8 bits wide or the low byte of a 16-bit bus. A timing reference is the four-byte run 0xFF, 0x00, 0x00 followed by a status byte XY. From the XY bytes the block rebuilds horizontal sync, vertical sync, field identity and an active-video window. Each kind of event it sees (start and end of active video, ancillary data headers, a cleared task bit, a field change, the start of horizontal and vertical sync) raises its own sticky flag in a status register.

A host reaches the block through a plain register port with two addresses. Address 0 is control: bit 0 enables decoding, bit 1 picks the capture clock edge (0 rising, 1 falling), bit 2 picks the sample rate (0 for 1x, 1 for 2x), and writing 1 to bit 3 clears the status flags. Bits 7:4 are spare storage that reads back as written. Address 1 is status. Its bits, from 6 down to 0, are SAV, EAV, ANC, TASK, field change, HSYNC start and VSYNC start. Bit 7 reads 0. Any write to status clears every flag.

The stream side uses valid/ready. `in_ready` is always high, because the decoder never holds off its source. A word is taken on every clock where `in_valid` is high. In 2x mode only the first of each pair of taken words counts as a new stream byte.

Top module: `embsync_decoder`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, and hsync_o, vsync_o, field_o and active_o are all 0.
- R2: A valid timing reference 0xFF,0x00,0x00,XY sets status bit 6 (SAV) when XY bit 4 is 0 and status bit 5 (EAV) when XY bit 4 is 1.
- R3: After a valid timing reference, hsync_o equals XY bit 4, vsync_o equals XY bit 5 and field_o equals XY bit 6. active_o is 1 after an SAV with XY bit 5 = 0 and is 0 after any other valid code. All of them hold their values until the next valid code.
- R4: The byte run 0x00,0xFF,0xFF sets status bit 4 (ANC).
- R5: A valid timing reference whose XY bit 7 is 0 sets status bit 3 (TASK). A code with bit 7 = 1 leaves that flag alone.
- R6: A valid code sets status bit 2 when its F bit differs from field_o. A valid EAV that arrives while hsync_o is 0 sets status bit 1. A valid code with V = 1 that arrives while vsync_o is 0 sets status bit 0.
- R7: XY must carry protection bits XY[3:0] = {V^H, F^H, F^V, F^V^H}. A code with any other low nibble sets no flag and changes no output.
- R8: Flags are sticky until cleared. Any write to address 1, or a write to address 0 with bit 3 = 1, clears all flags. Control bit 3 reads back 0 and status bit 7 reads 0. An event that lands in the same cycle as a clear is kept.
- R9: While control bit 0 is 0, no flag is set and all four sync outputs are 0.
- R10: With control bit 1 = 1, the stream is captured on the falling clock edge. A source that holds each word across the whole clock period then decodes exactly as it does with rising-edge capture.
- R11: With control bit 2 = 1, only the first, third, fifth and so on of the taken words are decoded, counted from the switch into 2x mode. The others are dropped.
- R12: in_ready is always 1, and a word is taken on each clock where in_valid is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Stream word present |
| in_ready | output | 1 | Always 1: the decoder never stalls |
| in_data | input | BUS_W | Stream word; the low byte carries the video data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| hsync_o | output | 1 | Horizontal blanking, from EAV to SAV |
| vsync_o | output | 1 | Vertical blanking bit of the last code |
| field_o | output | 1 | Field bit of the last code |
| active_o | output | 1 | Active video window |

## Verification
The collision that matters is a host clear of the status register in the same cycle that a decoded code raises a flag. The bench drives the XY byte and then places the status write one clock later, so that both reach the status register on the same edge. A correct design keeps the new SAV or EAV flag and drops the older flags. A second run puts the write one cycle later, and then every flag must read 0. Around these directed cases, random byte streams mixed with inserted codes, damaged codes, task codes and ancillary headers are compared against a byte-level model in the bench, under both capture edges and both rates.

// File: rtl/embsync_pkg.sv
package embsync_pkg;
  localparam int BYTE_W = 8;
  localparam int FLAG_N = 7;
  localparam int ST_SAV  = 6;
  localparam int ST_EAV  = 5;
  localparam int ST_ANC  = 4;
  localparam int ST_TASK = 3;
  localparam int ST_FLD  = 2;
  localparam int ST_HS   = 1;
  localparam int ST_VS   = 0;
  localparam int CT_EN   = 0;
  localparam int CT_EDGE = 1;
  localparam int CT_RATE = 2;
  localparam int CT_CLR  = 3;

  typedef logic [FLAG_N-1:0] flags_t;

  // protection nibble expected for a given F, V, H
  function automatic logic [3:0] prot_of(logic f, logic v, logic h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic xy_valid(logic [BYTE_W-1:0] b);
    return b[3:0] == prot_of(b[6], b[5], b[4]);
  endfunction
endpackage

// File: rtl/embsync_capture.sv
module embsync_capture #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_fall,
  input  logic             rate2x,
  input  logic             in_valid,
  input  logic [BUS_W-1:0] in_data,
  output logic             w_valid,
  output logic [BUS_W-1:0] w_data
);
  logic             n_valid;
  logic [BUS_W-1:0] n_data;
  logic             c_valid;
  logic [BUS_W-1:0] c_data;
  logic             phase;

  // falling-edge capture stage
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_valid <= 1'b0;
      n_data  <= '0;
    end else begin
      n_valid <= in_valid;
      n_data  <= in_data;
    end
  end

  // rising-edge capture, or retime of the falling-edge sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_valid <= 1'b0;
      c_data  <= '0;
    end else begin
      c_valid <= edge_fall ? n_valid : in_valid;
      c_data  <= edge_fall ? n_data  : in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= 1'b0;
    else if (!rate2x) phase <= 1'b0;
    else if (c_valid) phase <= ~phase;
  end

  assign w_valid = c_valid & (~rate2x | ~phase);
  assign w_data  = c_data;

  AST_RATE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (rate2x && w_valid) |=> !(rate2x && w_valid)); // R11
endmodule

// File: rtl/embsync_detect.sv
module embsync_detect
  import embsync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              b_valid,
  input  logic [BYTE_W-1:0] b_data,
  output flags_t            events,
  output logic              hs,
  output logic              vs,
  output logic              fd,
  output logic              act
);
  logic [BYTE_W-1:0] p1, p2, p3;
  logic trs, anc, code_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 <= '0;
      p2 <= '0;
      p3 <= '0;
    end else if (b_valid) begin
      p1 <= b_data;
      p2 <= p1;
      p3 <= p2;
    end
  end

  assign code_ok = xy_valid(b_data);
  assign trs = enable & b_valid & (p3 == 8'hFF) & (p2 == 8'h00) &
               (p1 == 8'h00) & code_ok;
  assign anc = enable & b_valid & (p2 == 8'h00) & (p1 == 8'hFF) &
               (b_data == 8'hFF);

  always_comb begin
    events          = '0;
    events[ST_SAV]  = trs & ~b_data[4];
    events[ST_EAV]  = trs &  b_data[4];
    events[ST_ANC]  = anc;
    events[ST_TASK] = trs & ~b_data[7];
    events[ST_FLD]  = trs & (b_data[6] != fd);
    events[ST_HS]   = trs & b_data[4] & ~hs;
    events[ST_VS]   = trs & b_data[5] & ~vs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs <= 1'b0; vs <= 1'b0; fd <= 1'b0; act <= 1'b0;
    end else if (!enable) begin
      hs <= 1'b0; vs <= 1'b0; fd <= 1'b0; act <= 1'b0;
    end else if (trs) begin
      hs  <= b_data[4];
      vs  <= b_data[5];
      fd  <= b_data[6];
      act <= ~b_data[4] & ~b_data[5];
    end
  end

  AST_HS_AFTER_EAV: assert property (@(posedge clk) disable iff (!rst_n)
    (trs && b_data[4]) |=> (hs && !act)); // R3
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hs && !vs && !fd && !act)); // R9
  AST_NO_EVENT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (events == '0)); // R9
endmodule

// File: rtl/embsync_regs.sv
module embsync_regs
  import embsync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  flags_t            events,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              en,
  output logic              edge_fall,
  output logic              rate2x
);
  logic [BYTE_W-1:0] ctrl_q;
  flags_t            stat_q;
  logic              clr;

  assign clr = reg_wr & (reg_addr | reg_wdata[CT_CLR]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (reg_wr && !reg_addr) begin
      ctrl_q         <= reg_wdata;
      ctrl_q[CT_CLR] <= 1'b0;
    end
  end

  // new events win over a clear landing in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (clr ? '0 : stat_q) | events;
  end

  assign en        = ctrl_q[CT_EN];
  assign edge_fall = ctrl_q[CT_EDGE];
  assign rate2x    = ctrl_q[CT_RATE];
  assign reg_rdata = reg_addr ? {1'b0, stat_q} : ctrl_q;

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R8
  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (events != '0) |=> ((stat_q & $past(events)) == $past(events))); // R8
  AST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && events == '0) |=> (stat_q == '0)); // R8
endmodule

// File: rtl/embsync_decoder.sv
module embsync_decoder
  import embsync_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BUS_W-1:0]  in_data,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              field_o,
  output logic              active_o
);
  logic             en, edge_fall, rate2x;
  logic             w_valid;
  logic [BUS_W-1:0] w_data;
  flags_t           events;

  assign in_ready = 1'b1;

  embsync_capture #(.BUS_W(BUS_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .edge_fall(edge_fall), .rate2x(rate2x),
    .in_valid(in_valid), .in_data(in_data),
    .w_valid(w_valid), .w_data(w_data)
  );

  embsync_detect u_det (
    .clk(clk), .rst_n(rst_n), .enable(en),
    .b_valid(w_valid), .b_data(w_data[BYTE_W-1:0]),
    .events(events), .hs(hsync_o), .vs(vsync_o), .fd(field_o), .act(active_o)
  );

  embsync_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .events(events), .reg_rdata(reg_rdata),
    .en(en), .edge_fall(edge_fall), .rate2x(rate2x)
  );
endmodule

// File: tb/tb_embsync_decoder.sv
`timescale 1ns/1ps
module tb_embsync_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic hsync_o, vsync_o, field_o, active_o;
  int n_chk = 0, n_fail = 0;

  // bench model state
  logic [6:0] m_st;
  logic m_h, m_v, m_f, m_a, m_en;
  logic [7:0] q1, q2, q3;

  always #5 clk = ~clk;

  embsync_decoder dut (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
    in_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic model_byte(logic [7:0] b);
    logic ok;
    ok = (b[3:0] == {b[5]^b[4], b[6]^b[4], b[6]^b[5], b[6]^b[5]^b[4]});
    if (m_en) begin
      if (q2 == 8'h00 && q1 == 8'hFF && b == 8'hFF) m_st[4] = 1'b1;
      if (q3 == 8'hFF && q2 == 8'h00 && q1 == 8'h00 && ok) begin
        if (b[4]) m_st[5] = 1'b1; else m_st[6] = 1'b1;
        if (!b[7]) m_st[3] = 1'b1;
        if (b[6] != m_f) m_st[2] = 1'b1;
        if (b[4] && !m_h) m_st[1] = 1'b1;
        if (b[5] && !m_v) m_st[0] = 1'b1;
        m_h = b[4]; m_v = b[5]; m_f = b[6]; m_a = !b[4] && !b[5];
      end
    end
    q3 = q2; q2 = q1; q1 = b;
  endtask

  // one decoded byte; in 2x mode a junk word follows
  task automatic send(logic [7:0] b, bit dbl);
    @(posedge clk); #2;
    in_valid = 1'b1; in_data = b; reg_wr = 1'b0;
    model_byte(b);
    if (dbl) begin
      @(posedge clk); #2;
      in_data = 8'($urandom);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(posedge clk); #2;
    in_valid = 1'b0; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a || d[3]) m_st = '0;
    if (!a) begin
      m_en = d[0];
      if (!d[0]) begin m_h = 0; m_v = 0; m_f = 0; m_a = 0; end
    end
    tick();
  endtask

  task automatic settle();
    repeat (3) tick();
  endtask

  task automatic check_all(string req);
    reg_addr = 1'b1; #1;
    chk({req, " status"}, reg_rdata, {1'b0, m_st});
    chk({req, " hsync"}, hsync_o, m_h);
    chk({req, " vsync"}, vsync_o, m_v);
    chk({req, " field"}, field_o, m_f);
    chk({req, " active"}, active_o, m_a);
  endtask

  function automatic logic [7:0] mk_xy(bit f, bit v, bit h, bit task0, bit bad);
    logic [7:0] b;
    b = {~task0, f, v, h, f^v^h ^ bad, 3'b0};
    b[3:0] = {v^h, f^h, f^v, f^v^h ^ bad};
    return b;
  endfunction

  task automatic send_code(logic [7:0] xy, bit dbl);
    send(8'hFF, dbl); send(8'h00, dbl); send(8'h00, dbl); send(xy, dbl);
  endtask

  task automatic random_run(string req, int n, bit dbl);
    for (int i = 0; i < n; i++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k < 3) send(8'($urandom), dbl);
      else if (k < 7) send_code(mk_xy($urandom_range(0,1), $urandom_range(0,1),
             $urandom_range(0,1), $urandom_range(0,3) == 0, 1'b0), dbl);
      else if (k == 7) send_code(mk_xy($urandom_range(0,1), $urandom_range(0,1),
             $urandom_range(0,1), 1'b0, 1'b1), dbl);
      else if (k == 8) begin send(8'h00, dbl); send(8'hFF, dbl); send(8'hFF, dbl); end
      else begin settle(); check_all(req); if ($urandom_range(0,1)) wr(1'b1, 8'h00); end
    end
    settle(); check_all(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R12 actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_st = '0; m_h = 0; m_v = 0; m_f = 0; m_a = 0; m_en = 0;
    q1 = '0; q2 = '0; q3 = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    reg_addr = 1'b0; #1;
    chk("R1 ctrl", reg_rdata, 8'h00);
    check_all("R1");
    chk("R12 ready", in_ready, 1'b1);

    // R9 disabled: codes ignored
    send_code(mk_xy(1, 1, 1, 1'b1, 1'b0), 0);
    send(8'h00, 0); send(8'hFF, 0); send(8'hFF, 0);
    settle(); check_all("R9");

    wr(1'b0, 8'h01);
    // R2/R3 SAV active line, then EAV
    send_code(mk_xy(0, 0, 0, 0, 0), 0); settle(); check_all("R2 sav");
    chk("R3 active", active_o, 1'b1);
    send_code(mk_xy(0, 0, 1, 0, 0), 0); settle(); check_all("R2 eav");
    chk("R6 hs flag", reg_rdata[1], 1'b1);
    wr(1'b1, 8'h00); settle(); check_all("R8 clear");
    // R7 damaged code
    send_code(mk_xy(1, 1, 0, 1, 1), 0); settle(); check_all("R7");
    chk("R7 status", reg_rdata, 8'h00);
    // R5 task, R6 field and vsync
    send_code(mk_xy(1, 1, 0, 1, 0), 0); settle(); check_all("R5 R6");
    chk("R5 task", reg_rdata[3], 1'b1);
    chk("R6 field", reg_rdata[2], 1'b1);
    // R4 ancillary header
    send(8'h00, 0); send(8'hFF, 0); send(8'hFF, 0); settle(); check_all("R4");
    // R8 ctrl bit3 clear and readback
    wr(1'b0, 8'hF9); reg_addr = 1'b0; #1;
    chk("R8 ctrl read", reg_rdata, 8'hF1);
    settle(); check_all("R8 ctrl clear");
    // R8 collision: event and clear on the same edge
    send_code(mk_xy(0, 0, 1, 0, 0), 0);
    send_code(mk_xy(0, 0, 0, 0, 0), 0);
    @(posedge clk); #2;
    in_valid = 1'b0; reg_wr = 1'b1; reg_addr = 1'b1;
    tick();
    m_st = 7'b100_0000;
    settle(); check_all("R8 collide");
    wr(1'b1, 8'h00); settle(); check_all("R8 after");

    random_run("R2 R3 rise", 120, 0);
    wr(1'b0, 8'h03);
    random_run("R10 fall", 120, 0);
    wr(1'b0, 8'h05);
    random_run("R11 2x", 120, 1);
    wr(1'b0, 8'h07);
    random_run("R11 R10 2x fall", 80, 1);
    wr(1'b0, 8'h00); settle(); check_all("R9 off");

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule